// File: doc/BRIEF.md
# Split-Section Decade Counter

This block is a four-bit counter made of two sections that share one system clock. A one-bit section divides its count strobe by two. A three-bit section divides its own count strobe by five. Either section can run alone. A chain select can also link them into a counter that steps through binary-coded decimal values 0 to 9. Each count strobe is an ordinary level signal. The block samples it on the system clock and counts on its high-to-low transition, so no derived clocks are needed.

There are two forcing controls, and each is formed by AND-ing a pair of inputs. When both clear inputs are high, all four bits go to zero. When both nine inputs are high, the counter is loaded with binary 1001 (qd=1, qc=0, qb=0, qa=1). A force takes effect on the next clock edge and replaces any count step in that cycle. When both forces arrive together, loading nine wins.

Top module: `dec_split_counter`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs become 0 on that edge.
- R2: With no force active, `qa` toggles on the edge where `tick_a` is sampled low after having been sampled high on the previous edge. Otherwise `qa` holds.
- R3: With `chain` low, each high-to-low transition of `tick_b` steps {qd,qc,qb} through 000, 001, 010, 011, 100 and then back to 000. The value never exceeds 100.
- R4: With `chain` low, the two sections are independent: `tick_a` transitions never move {qd,qc,qb}, and `tick_b` transitions never move `qa`.
- R5: With `chain` high, {qd,qc,qb} steps on the same edge where `qa` toggles from 1 to 0, and `tick_b` is ignored. The 4-bit value {qd,qc,qb,qa} then counts 0,1,...,9,0.
- R6: If both `clr_p` and `clr_q` are high at an edge, the outputs become 0000. Either input high on its own has no effect.
- R7: If both `nine_p` and `nine_q` are high at an edge, {qd,qc,qb,qa} becomes 1001. Either input high on its own has no effect.
- R8: When both clear inputs and both nine inputs are high at the same edge, the result is 1001.
- R9: A clear or a nine load replaces a count step that falls on the same edge.
- R10: A low-to-high transition on a count strobe does not step its section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Count strobe of the divide-by-2 section |
| tick_b | input | 1 | Count strobe of the divide-by-5 section |
| chain | input | 1 | 1: the divide-by-5 section counts on the carry out of `qa` |
| clr_p | input | 1 | Clear request, first of the AND-ed pair |
| clr_q | input | 1 | Clear request, second of the AND-ed pair |
| nine_p | input | 1 | Load-nine request, first of the AND-ed pair |
| nine_q | input | 1 | Load-nine request, second of the AND-ed pair |
| qa | output | 1 | Divide-by-2 section bit (weight 1) |
| qb | output | 1 | Divide-by-5 section bit 0 (weight 2) |
| qc | output | 1 | Divide-by-5 section bit 1 (weight 4) |
| qd | output | 1 | Divide-by-5 section bit 2 (weight 8) |

## Verification
Three events can land on the same clock edge: a count step, a clear and a nine load. The bench times a strobe's falling transition so that its counting edge is also the edge where both clear inputs, or both nine inputs, are high. It then checks that the forced value is present and that no count step was applied on top of it. It also raises both force pairs together and expects 1001. In chained mode it arranges for the carry out of `qa` to coincide with a `tick_b` fall, and checks that the upper section moves only once.

// File: rtl/dec_split_pkg.sv
package dec_split_pkg;

    localparam int LO_W    = 1;
    localparam int LO_LAST = 1;
    localparam int HI_W    = 3;
    localparam int HI_LAST = 4;
    localparam int LANES   = 2;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_NINE  = 2'd3
    } act_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cnt_t;

    localparam cnt_t NINE_VAL = '{hi: 3'd4, lo: 1'b1};

    // Load nine outranks clear; both outrank a count step.
    function automatic act_e pick_act(input logic clr, input logic nine, input logic step);
        if (nine)
            return ACT_NINE;
        else if (clr)
            return ACT_CLEAR;
        else if (step)
            return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/dec_edge.sv
module dec_edge #(
    parameter bit FALL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b0;
        else
            prev <= lvl;
    end

    generate
        if (FALL) begin : g_fall
            assign evt = prev & ~lvl;
        end else begin : g_rise
            assign evt = ~prev & lvl;
        end
    endgenerate

endmodule

// File: rtl/dec_section.sv
module dec_section
    import dec_split_pkg::*;
#(
    parameter int            W    = 3,
    parameter int            LAST = 4,
    parameter logic [W-1:0]  LOADV = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    output logic [W-1:0] val
);
    localparam logic [W-1:0] TOP = W'(LAST);

    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else begin
            unique case (act)
                ACT_NINE:  val <= LOADV;
                ACT_CLEAR: val <= '0;
                ACT_STEP:  val <= (val == TOP) ? '0 : val + 1'b1;
                default:   val <= val;
            endcase
        end
    end

    AST_SECTION_RANGE: assert property (@(posedge clk) disable iff (rst)
        val <= TOP);  // R3

    AST_SECTION_WRAP: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP && val == TOP) |=> val == '0);  // R3

endmodule

// File: rtl/dec_split_counter.sv
module dec_split_counter
    import dec_split_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_a,
    input  logic tick_b,
    input  logic chain,
    input  logic clr_p,
    input  logic clr_q,
    input  logic nine_p,
    input  logic nine_q,
    output logic qa,
    output logic qb,
    output logic qc,
    output logic qd
);
    logic [LANES-1:0] tick_in;
    logic [LANES-1:0] tick_evt;
    cnt_t             cnt;
    logic             force_clr;
    logic             force_nine;
    logic             hi_step;
    act_e             act_lo;
    act_e             act_hi;

    assign tick_in = {tick_b, tick_a};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dec_edge #(.FALL(1'b1)) u_edge (
                .clk (clk),
                .rst (rst),
                .lvl (tick_in[g]),
                .evt (tick_evt[g])
            );
        end
    endgenerate

    assign force_clr  = clr_p & clr_q;
    assign force_nine = nine_p & nine_q;

    // Chained: the upper section counts on the lower bit's 1->0 step.
    assign hi_step = chain ? (tick_evt[0] & cnt.lo[0]) : tick_evt[1];

    assign act_lo = pick_act(force_clr, force_nine, tick_evt[0]);
    assign act_hi = pick_act(force_clr, force_nine, hi_step);

    dec_section #(.W(LO_W), .LAST(LO_LAST), .LOADV(NINE_VAL.lo)) u_lo (
        .clk (clk),
        .rst (rst),
        .act (act_lo),
        .val (cnt.lo)
    );

    dec_section #(.W(HI_W), .LAST(HI_LAST), .LOADV(NINE_VAL.hi)) u_hi (
        .clk (clk),
        .rst (rst),
        .act (act_hi),
        .val (cnt.hi)
    );

    assign qa = cnt.lo[0];
    assign qb = cnt.hi[0];
    assign qc = cnt.hi[1];
    assign qd = cnt.hi[2];

    AST_NINE_WINS: assert property (@(posedge clk) disable iff (rst)
        force_nine |=> {qd, qc, qb, qa} == 4'b1001);  // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (force_clr && !force_nine) |=> {qd, qc, qb, qa} == 4'b0000);  // R6

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!force_clr && !force_nine && !tick_evt[0]) |=> $stable(qa));  // R2

    AST_HI_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!chain && !force_clr && !force_nine && !tick_evt[1]) |=> $stable(cnt.hi));  // R4

    AST_CHAIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (chain && !force_clr && !force_nine && tick_evt[0] && qa)
        |=> (!qa && cnt.hi != $past(cnt.hi)));  // R5

    AST_CHAIN_IGNORE_B: assert property (@(posedge clk) disable iff (rst)
        (chain && !force_clr && !force_nine && !(tick_evt[0] && qa)) |=> $stable(cnt.hi));  // R5

endmodule

// File: tb/dec_split_counter_test.sv
`timescale 1ns/1ps
module dec_split_counter_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_a = 1'b0, tick_b = 1'b0, chain = 1'b0;
    logic clr_p = 1'b0, clr_q = 1'b0, nine_p = 1'b0, nine_q = 1'b0;
    logic qa, qb, qc, qd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic       e_a;
    logic [2:0] e_b;

    always #2 clk = ~clk;

    dec_split_counter uut (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .chain(chain),
        .clr_p(clr_p), .clr_q(clr_q), .nine_p(nine_p), .nine_q(nine_q),
        .qa(qa), .qb(qb), .qc(qc), .qd(qd)
    );

    function automatic logic [3:0] outv();
        return {qd, qc, qb, qa};
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Strobe high for one cycle then low; the count edge is the second posedge.
    task automatic pulse(input bit which_b);
        tick();
        if (which_b) tick_b = 1'b1; else tick_a = 1'b1;
        tick();
        if (which_b) tick_b = 1'b0; else tick_a = 1'b0;
        tick();
    endtask

    task automatic do_reset();
        rst = 1'b1; chain = 1'b0;
        tick(); tick();
        rst = 1'b0;
        e_a = 1'b0; e_b = 3'd0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", outv(), 4'b0000);
    endtask

    task automatic t_mod2();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            pulse(1'b0);
            e_a = ~e_a;
            check("R2 lower toggle", outv(), {e_b, e_a});
        end
        tick(); tick_a = 1'b1;
        tick(); tick();
        check("R10 rise no step", outv(), {e_b, e_a});
        tick(); tick();
        check("R2 held level", outv(), {e_b, e_a});
        tick_a = 1'b0;
        tick();
        e_a = ~e_a;
        check("R2 fall after hold", outv(), {e_b, e_a});
    endtask

    task automatic t_mod5();
        do_reset();
        for (int i = 0; i < 7; i++) begin
            pulse(1'b1);
            e_b = (e_b == 3'd4) ? 3'd0 : e_b + 3'd1;
            check("R3 upper sequence", outv(), {e_b, e_a});
        end
        check("R4 lower untouched by tick_b", {3'b000, qa}, {3'b000, e_a});
    endtask

    task automatic t_indep();
        do_reset();
        pulse(1'b1); e_b = 3'd1;
        pulse(1'b0); e_a = 1'b1;
        pulse(1'b0); e_a = 1'b0;
        check("R4 upper untouched by tick_a", outv(), {e_b, e_a});
    endtask

    task automatic t_clear();
        do_reset();
        pulse(1'b1); pulse(1'b0);
        e_b = 3'd1; e_a = 1'b1;
        clr_p = 1'b1; tick(); clr_p = 1'b0;
        check("R6 clr_p alone", outv(), {e_b, e_a});
        clr_q = 1'b1; tick(); clr_q = 1'b0;
        check("R6 clr_q alone", outv(), {e_b, e_a});
        clr_p = 1'b1; clr_q = 1'b1; tick(); clr_p = 1'b0; clr_q = 1'b0;
        e_a = 1'b0; e_b = 3'd0;
        check("R6 both clear", outv(), 4'b0000);
    endtask

    task automatic t_nine();
        do_reset();
        nine_p = 1'b1; tick(); nine_p = 1'b0;
        check("R7 nine_p alone", outv(), 4'b0000);
        nine_q = 1'b1; tick(); nine_q = 1'b0;
        check("R7 nine_q alone", outv(), 4'b0000);
        nine_p = 1'b1; nine_q = 1'b1; tick(); nine_p = 1'b0; nine_q = 1'b0;
        check("R7 load nine", outv(), 4'b1001);
        clr_p = 1'b1; clr_q = 1'b1; nine_p = 1'b1; nine_q = 1'b1;
        tick();
        clr_p = 1'b0; clr_q = 1'b0; nine_p = 1'b0; nine_q = 1'b0;
        check("R8 nine beats clear", outv(), 4'b1001);
        clr_p = 1'b1; clr_q = 1'b1; tick(); clr_p = 1'b0; clr_q = 1'b0;
        clr_p = 1'b1; clr_q = 1'b1; nine_p = 1'b1; nine_q = 1'b1;
        tick();
        clr_p = 1'b0; clr_q = 1'b0; nine_p = 1'b0; nine_q = 1'b0;
        check("R8 nine beats clear from zero", outv(), 4'b1001);
    endtask

    task automatic t_override();
        do_reset();
        pulse(1'b0); pulse(1'b1);
        tick(); tick_a = 1'b1; tick_b = 1'b1;
        tick(); tick_a = 1'b0; tick_b = 1'b0; clr_p = 1'b1; clr_q = 1'b1;
        tick(); clr_p = 1'b0; clr_q = 1'b0;
        check("R9 clear over step", outv(), 4'b0000);
        tick(); tick_a = 1'b1; tick_b = 1'b1;
        tick(); tick_a = 1'b0; tick_b = 1'b0; nine_p = 1'b1; nine_q = 1'b1;
        tick(); nine_p = 1'b0; nine_q = 1'b0;
        check("R9 nine over step", outv(), 4'b1001);
    endtask

    task automatic t_decade();
        int n = 0;
        do_reset();
        chain = 1'b1;
        for (int i = 0; i < 12; i++) begin
            pulse(1'b0);
            n = (n + 1) % 10;
            check("R5 decade count", outv(), 4'(n));
            if (i == 4) begin
                pulse(1'b1);
                check("R5 tick_b ignored", outv(), 4'(n));
            end
        end
        // count is 2; step to 3, then carry while tick_b also falls
        pulse(1'b0); n = 3;
        tick(); tick_a = 1'b1; tick_b = 1'b1;
        tick(); tick_a = 1'b0; tick_b = 1'b0;
        tick();
        n = 4;
        check("R5 carry with tick_b fall", outv(), 4'(n));
        chain = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_mod2();
        t_mod5();
        t_indep();
        t_clear();
        t_nine();
        t_override();
        t_decade();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

endmodule